// File: doc/BRIEF.md
# Single-Wire Bus Master Controller

This block is the master side of an open-drain single-wire bus. It can generate three operations: a bus reset with presence detection, a write time slot that carries one bit, and a read time slot that samples one bit sent by a slave. A user asks for an operation by raising one of three command strobes. The block runs the whole waveform on its own and then raises `done` for one clock.

All timing is counted in microseconds. A tick divider sets the microsecond length from the system clock, and it restarts when each command is accepted, so every edge of an operation falls on an exact clock count after the request. The block never drives the line high. It only enables a pull-low driver (`bus_pull_low`) and watches the line through a synchronizer. An external resistor returns the line high.

Each operation has fixed timing, set by parameters:
- Reset: the line is held low for 480 µs and then released for 480 µs. Presence is sampled 70 µs after the release.
- Write slots: the slot lasts 65 µs and is followed by 3 µs of recovery. A 1 is sent with a 6 µs low pulse, and a 0 with a 60 µs low pulse.
- Read slots: the line is held low for 6 µs and sampled 15 µs after the slot starts.

A command that arrives while an operation is in progress is dropped.

Top module: `swb_master`

## Requirements
- R1: After synchronous reset, `bus_pull_low`, `busy`, `done`, `rd_bit` and `presence` are all 0.
- R2: A reset operation enables the pull-low from the clock after the request for exactly T_RST_LOW×CLK_PER_US clocks, then keeps the line released for the rest of the operation.
- R3: In a reset operation, `presence` is set to 1 if the synchronized line is low at T_RST_LOW+T_PRES_SMP µs after the start, and to 0 if it is high there.
- R4: A write with `wr_bit`=1 pulls the line low for exactly T_LOW_SHORT×CLK_PER_US clocks and then releases it.
- R5: A write with `wr_bit`=0 pulls the line low for exactly T_LOW_ZERO×CLK_PER_US clocks and then releases it.
- R6: A read pulls the line low for T_LOW_SHORT×CLK_PER_US clocks. The synchronized line level at T_RD_SMP µs after the start is stored in `rd_bit`: high gives 1, low gives 0.
- R7: `done` is a single-clock pulse. For a slot it is seen (T_SLOT+T_REC)×CLK_PER_US+1 clock edges after the accepting edge, and for a reset (T_RST_LOW+T_RST_HIGH)×CLK_PER_US+1 edges after it. `busy` is 1 from the accepting edge until `done`.
- R8: A command raised while `busy` is 1 is ignored: the waveform and completion time of the running operation do not change.
- R9: If several strobes are raised together while idle, reset wins over write, and write wins over read.
- R10: The line is never pulled low while idle. `rd_bit` changes only in read operations, and `presence` changes only in reset operations.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_reset | input | 1 | Request a reset/presence operation |
| cmd_write | input | 1 | Request a write slot |
| cmd_read | input | 1 | Request a read slot |
| wr_bit | input | 1 | Bit to send with a write request |
| bus_in | input | 1 | Raw line level (asynchronous) |
| bus_pull_low | output | 1 | 1 enables the open-drain pull-low driver |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-clock completion pulse |
| rd_bit | output | 1 | Bit captured by the last read slot |
| presence | output | 1 | Presence result of the last reset |

## Verification
The bench counts the exact number of clocks the line is pulled low and the clock on which `done` appears, for every operation type. A divider that is not restarted on each command would show up as a low time or a completion time that is off by a fraction of a microsecond. A design that gets the sample point or the sample polarity wrong would fail in a specific way: the slave model pulls the line low only inside a window around the correct sample point, so sampling too early or too late reads the wrong bit or the wrong presence. The bench also raises a stray command in the middle of an operation and all three strobes at once. A design that accepts commands while busy would restart or stretch the waveform. A design with the wrong priority order would produce a slot where a reset was expected. Write and read slots that follow each other check that `presence` and `rd_bit` keep their values across operations that must not touch them.

// File: rtl/swb_pkg.sv
package swb_pkg;
  typedef enum logic [1:0] {
    OP_RST = 2'd0,
    OP_WR0 = 2'd1,
    OP_WR1 = 2'd2,
    OP_RD  = 2'd3
  } swb_op_e;
endpackage

// File: rtl/swb_us_tick.sv
module swb_us_tick #(
  parameter int DIV = 100
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  output logic tick
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;

  logic [CW-1:0] cnt_q;

  assign tick = (cnt_q == CW'(DIV - 1));

  always_ff @(posedge clk) begin
    if (rst || clr) cnt_q <= '0;
    else if (tick)  cnt_q <= '0;
    else            cnt_q <= cnt_q + 1'b1;
  end

  generate
    if (DIV > 1) begin : g_gap
      // R2
      tick_gap_chk: assert property (@(posedge clk) disable iff (rst)
        tick |=> !tick);
    end
  endgenerate
endmodule

// File: rtl/swb_sync.sv
module swb_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk) begin
    if (rst) sh_q <= '1;
    else     sh_q <= {sh_q[STAGES-2:0], d};
  end

  assign q = sh_q[STAGES-1];
endmodule

// File: rtl/swb_master.sv
module swb_master
  import swb_pkg::*;
#(
  parameter int CLK_PER_US  = 100,
  parameter int T_RST_LOW   = 480,
  parameter int T_RST_HIGH  = 480,
  parameter int T_PRES_SMP  = 70,
  parameter int T_SLOT      = 65,
  parameter int T_REC       = 3,
  parameter int T_LOW_SHORT = 6,
  parameter int T_LOW_ZERO  = 60,
  parameter int T_RD_SMP    = 15,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic cmd_reset,
  input  logic cmd_write,
  input  logic cmd_read,
  input  logic wr_bit,
  input  logic bus_in,
  output logic bus_pull_low,
  output logic busy,
  output logic done,
  output logic rd_bit,
  output logic presence
);
  localparam int T_MAX = T_RST_LOW + T_RST_HIGH;
  localparam int US_W  = $clog2(T_MAX + 1);

  logic          tick, bus_s, start;
  logic          busy_q, oe_q, done_q, rd_q, pres_q;
  logic [US_W-1:0] us_q, us_nxt;
  logic [US_W-1:0] low_len, smp_pt, end_pt;
  logic          smp_en;
  swb_op_e       op_q, start_op;

  swb_us_tick #(.DIV(CLK_PER_US)) i_tick (
    .clk(clk), .rst(rst), .clr(start), .tick(tick)
  );

  swb_sync #(.STAGES(SYNC_STAGES)) i_sync (
    .clk(clk), .rst(rst), .d(bus_in), .q(bus_s)
  );

  assign start = !busy_q && (cmd_reset || cmd_write || cmd_read);
  assign us_nxt = us_q + 1'b1;

  always_comb begin
    if (cmd_reset)      start_op = OP_RST;
    else if (cmd_write) start_op = wr_bit ? OP_WR1 : OP_WR0;
    else                start_op = OP_RD;
  end

  always_comb begin
    smp_en = 1'b0;
    smp_pt = US_W'(T_RD_SMP);
    end_pt = US_W'(T_SLOT + T_REC);
    case (op_q)
      OP_RST: begin
        low_len = US_W'(T_RST_LOW);
        smp_pt  = US_W'(T_RST_LOW + T_PRES_SMP);
        smp_en  = 1'b1;
        end_pt  = US_W'(T_MAX);
      end
      OP_WR0:  low_len = US_W'(T_LOW_ZERO);
      OP_WR1:  low_len = US_W'(T_LOW_SHORT);
      default: begin
        low_len = US_W'(T_LOW_SHORT);
        smp_en  = 1'b1;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      oe_q   <= 1'b0;
      done_q <= 1'b0;
      rd_q   <= 1'b0;
      pres_q <= 1'b0;
      us_q   <= '0;
      op_q   <= OP_RST;
    end else begin
      done_q <= 1'b0;
      if (!busy_q) begin
        if (start) begin
          busy_q <= 1'b1;
          oe_q   <= 1'b1;
          us_q   <= '0;
          op_q   <= start_op;
        end
      end else if (tick) begin
        us_q <= us_nxt;
        if (us_nxt == low_len) oe_q <= 1'b0;
        if (smp_en && us_nxt == smp_pt) begin
          if (op_q == OP_RD) rd_q   <= bus_s;
          else               pres_q <= !bus_s;
        end
        if (us_nxt == end_pt) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  assign bus_pull_low = oe_q;
  assign busy         = busy_q;
  assign done         = done_q;
  assign rd_bit       = rd_q;
  assign presence     = pres_q;

  // R10
  idle_release_chk: assert property (@(posedge clk) disable iff (rst)
    !busy_q |-> !oe_q);
  // R10
  rd_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !busy_q |=> $stable(rd_q));
  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done_q |=> !done_q);
  // R7
  done_after_busy_chk: assert property (@(posedge clk) disable iff (rst)
    done_q |-> (!busy_q && $past(busy_q)));
  // R8
  pull_start_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(oe_q) |-> $past(!busy_q));
  // R7
  us_bound_chk: assert property (@(posedge clk) disable iff (rst)
    us_q <= US_W'(T_MAX));
endmodule

// File: tb/test_swb_master.sv
module test_swb_master;
  localparam int N       = 4;
  localparam int RST_LOW = 480;
  localparam int RST_TOT = 960;
  localparam int PRES    = 70;
  localparam int SLOT    = 68;
  localparam int LSHORT  = 6;
  localparam int LZERO   = 60;

  logic clk = 1'b0, rst = 1'b1;
  logic cmd_reset = 0, cmd_write = 0, cmd_read = 0, wr_bit = 0;
  logic slave_low = 0;
  logic bus_in, bus_pull_low, busy, done, rd_bit, presence;
  int   n_cmp = 0, n_bad = 0;
  bit   exp_rd = 0, exp_pres = 0;

  assign bus_in = !(bus_pull_low || slave_low);

  always #5 clk = ~clk;

  swb_master #(.CLK_PER_US(N)) i_swb_master (
    .clk(clk), .rst(rst), .cmd_reset(cmd_reset), .cmd_write(cmd_write),
    .cmd_read(cmd_read), .wr_bit(wr_bit), .bus_in(bus_in),
    .bus_pull_low(bus_pull_low), .busy(busy), .done(done),
    .rd_bit(rd_bit), .presence(presence)
  );

  task automatic check(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int low_us(input int kind, input bit b);
    if (kind == 0 || kind == 3) return RST_LOW;
    if (kind == 1) return b ? LSHORT : LZERO;
    return LSHORT;
  endfunction

  function automatic int end_us(input int kind);
    return (kind == 0 || kind == 3) ? RST_TOT : SLOT;
  endfunction

  // kind: 0 reset, 1 write, 2 read, 3 all strobes together
  task automatic do_op(input int kind, input bit b, input bit sbit, input bit stray);
    int low_cnt = 0, done_at = 0, done_cnt = 0;
    bit busy_early = 0;
    bit is_rst = (kind == 0 || kind == 3);
    string tag = (kind == 3) ? "R9" : (kind == 0) ? "R2" :
                 (kind == 2) ? "R6" : (b ? "R4" : "R5");
    @(negedge clk);
    cmd_reset = (kind == 0 || kind == 3);
    cmd_write = (kind == 1 || kind == 3);
    cmd_read  = (kind == 2 || kind == 3);
    wr_bit = b;
    for (int n = 1; n < 6000; n++) begin
      @(negedge clk);
      cmd_reset = 0; cmd_write = 0; cmd_read = 0;
      if (stray && n == 10) begin cmd_reset = 1; cmd_read = 1; end
      if (is_rst)
        slave_low = sbit && n >= (RST_LOW + 15) * N && n <= (RST_LOW + 200) * N;
      else if (kind == 2)
        slave_low = !sbit && n >= 2 * N && n <= 40 * N;
      else
        slave_low = 0;
      if (n == 1) busy_early = busy;
      if (bus_pull_low) low_cnt++;
      if (done) begin done_at = n; break; end
    end
    slave_low = 0;
    check({tag, " low time"}, low_cnt, low_us(kind, b) * N);
    check("R7 done time", done_at, end_us(kind) * N + 1);
    check("R7 busy after accept", busy_early, 1);
    if (stray) check("R8 stray ignored", done_at, end_us(kind) * N + 1);
    if (is_rst) exp_pres = sbit;
    if (kind == 2) exp_rd = sbit;
    @(negedge clk);
    check("R7 done one cycle", done, 0);
    check("R3 presence", presence, exp_pres);
    check("R6/R10 rd_bit", rd_bit, exp_rd);
    check("R10 idle release", bus_pull_low, 0);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (4) @(posedge clk);
    @(negedge clk); rst = 0;
    // R1
    check("R1 pull", bus_pull_low, 0);
    check("R1 busy", busy, 0);
    check("R1 done", done, 0);
    check("R1 rd_bit", rd_bit, 0);
    check("R1 presence", presence, 0);
    repeat (20) @(negedge clk);
    check("R10 idle no pull", bus_pull_low, 0);
    // directed corners
    do_op(0, 0, 1, 0);   // R2 R3 present
    do_op(2, 0, 1, 0);   // R6 read 1
    do_op(2, 0, 0, 0);   // R6 read 0
    do_op(1, 1, 0, 0);   // R4
    do_op(1, 0, 0, 0);   // R5
    do_op(1, 0, 0, 1);   // R8 stray during write
    do_op(3, 1, 0, 0);   // R9 all together -> reset, absent
    do_op(0, 0, 1, 1);   // R8 stray during reset
    // random mix
    for (int i = 0; i < 40; i++) begin
      int r = $urandom_range(0, 9);
      int k = (r == 0) ? 0 : (r < 5) ? 1 : 2;
      do_op(k, 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
            1'($urandom_range(0, 3) == 0));
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule